// File: doc/BRIEF.md
# Write-only serial control port for a stereo audio processor

This block is the control front end of a stereo audio processor. It listens on a two-wire serial bus (SCL, SDA) and samples both lines with the system clock. It pulls SDA low to acknowledge bytes it accepts. A transfer starts with a device address byte that carries the write flag. Next comes a sub-address byte that loads an internal pointer. Each data byte after that lands in the register the pointer names, and the pointer then steps forward by one. A single transfer can therefore fill several registers in a row.

The outputs are decoded control fields, ready for the analog section:
- input source and input gain code
- left and right volume
- operating mode and surround mode
- level of the summed (L+R) output
- bass and treble settings

The volume register is special. Its two top bits steer one write to the left volume, the right volume, or both. Each accepted register write raises a one-cycle update strobe together with the register's address. Downstream logic can use it to apply the change without clicks.

Top module: `audio_ctl_i2c_slave`

## Requirements
- R1: Only the address byte 0xEE (7-bit address 0x77 with the write flag 0) is acknowledged. Any other value, including the read form 0xEF, is not acknowledged. No byte after it is acknowledged or stored until the next START.
- R2: For each accepted byte, the slave pulls SDA low (sda_pull_o = 1) from the SCL falling edge after the eighth bit until the next SCL falling edge. SDA is released at all other times. Bits arrive MSB first and are taken on SCL rising edges.
- R3: SDA falling while SCL is high (START) aborts any partly received byte and restarts address decoding. SDA rising while SCL is high (STOP) ends the transfer.
- R4: The byte after the address loads the pointer. Each data byte is written to the register the pointer names, and the pointer then increases by one.
- R5: Register 1 sets the input source and the input gain. Bits [2:0] drive input_sel_o (0 mute, 1 to 3 inputs A to C). Bits [7:3] drive in_gain_o.
- R6: In register 2, bit 6 enables a write of the left volume and bit 7 enables a write of the right volume, both from bits [5:0]. When both bits are 0, the byte changes nothing and raises no strobe.
- R7: A volume code of 49 to 63 is stored as 48, which means fully muted.
- R8: Register 3 sets three fields. Bits [1:0] drive mode_o (0 bypass, 1 matrix, 2 mono, 3 pseudo-stereo). Bits [7:5] drive sum_gain_o. Bits [4:2] are the surround mode, and surround_o reads 0 while mode_o is 2 (mono).
- R9: Registers 4 (bass) and 5 (treble) use sign-magnitude form. Bit 4 is the cut flag and bits [3:0] are the step count. The step count is clamped to 10 for bass and to 9 for treble.
- R10: A data byte aimed at pointer 0 or at a pointer above 5 is still acknowledged. It changes no register and raises no strobe.
- R11: After reset, the outputs are in a safe state. The input is muted, both volumes are 48, and every other field is 0. SDA is released.
- R12: Each register write raises upd_o for exactly one cycle, with upd_addr_o giving the register number (1 to 5). The new field values appear in that same cycle.
- R13: Both lines pass through a synchronizer and a glitch filter. A pulse shorter than FILT_LEN clock cycles on either line has no effect on the received data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line, as seen on the bus |
| sda_pull_o | output | 1 | When 1, the open-drain driver pulls SDA low |
| input_sel_o | output | 3 | Input source code |
| in_gain_o | output | 5 | Input gain code |
| vol_left_o | output | 6 | Left volume code (0 to 48) |
| vol_right_o | output | 6 | Right volume code (0 to 48) |
| mode_o | output | 2 | Operating mode |
| surround_o | output | 3 | Effective surround mode (0 while the mode is mono) |
| sum_gain_o | output | 3 | Summed output level (0 mute to 7) |
| bass_o | output | 5 | Bass setting: {cut, steps} |
| treble_o | output | 5 | Treble setting: {cut, steps} |
| upd_o | output | 1 | One-cycle strobe on each register write |
| upd_addr_o | output | 3 | Register number written when upd_o is 1 |

## Verification
The bench sweeps all 64 volume codes and all 32 tone codes.
- A design without the volume clamp would store codes 49 to 63 raw, and the sweep would see the wrong volume.
- A design with the wrong magnitude limits would leave 11 to 15 steps in a tone register.

The bench also drives these corner cases:
- Channel-select value 00: a design that writes anyway would corrupt both volumes.
- Pointers out of range: a design that wraps the pointer would corrupt a real register.
- The read address: a design that acknowledges it would store the bytes that follow.
- A START in the middle of a byte: a design that does not reset its bit count would misalign every byte after it.
- A one-cycle SCL spike: a design without filtering would shift in an extra bit.

// File: rtl/audio_ctl_pkg.sv
package audio_ctl_pkg;
  typedef enum logic [1:0] {PH_ADDR, PH_SUB, PH_DATA} phase_e;

  localparam logic [5:0] VOL_MUTE   = 6'd48;
  localparam logic [3:0] BASS_MAX   = 4'd10;
  localparam logic [3:0] TREBLE_MAX = 4'd9;
  localparam logic [1:0] MODE_MONO  = 2'd2;

  function automatic logic [5:0] vol_clamp(input logic [5:0] code);
    return (code > VOL_MUTE) ? VOL_MUTE : code;
  endfunction

  function automatic logic [4:0] tone_clamp(input logic [4:0] raw, input logic [3:0] lim);
    return {raw[4], (raw[3:0] > lim) ? lim : raw[3:0]};
  endfunction
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 2'b11;
      cnt_q   <= '0;
      level_o <= 1'b1;
      rise_o  <= 1'b0;
      fall_o  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      rise_o <= 1'b0;
      fall_o <= 1'b0;
      if (sync_q[1] == level_o) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        cnt_q   <= '0;
        level_o <= sync_q[1];
        rise_o  <= sync_q[1];
        fall_o  <= ~sync_q[1];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R13: the filtered level moves only together with a reported edge
  assert_edge_consistent_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o != $past(level_o)) |-> (rise_o || fall_o));
endmodule

// File: rtl/i2c_wr_engine.sv
module i2c_wr_engine
  import audio_ctl_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR = 8'hEE
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       sda_i,
  input  logic       sda_rise_i,
  input  logic       sda_fall_i,
  output logic       sda_pull_o,
  output logic       byte_vld_o,
  output logic       byte_is_sub_o,
  output logic [7:0] byte_o
);
  logic       active_q, in_ack_q;
  logic [3:0] bcnt_q;
  logic [7:0] shreg_q;
  phase_e     phase_q;

  wire start_cond = sda_fall_i & scl_i;
  wire stop_cond  = sda_rise_i & scl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q      <= 1'b0;
      in_ack_q      <= 1'b0;
      bcnt_q        <= '0;
      shreg_q       <= '0;
      phase_q       <= PH_ADDR;
      sda_pull_o    <= 1'b0;
      byte_vld_o    <= 1'b0;
      byte_is_sub_o <= 1'b0;
      byte_o        <= '0;
    end else begin
      byte_vld_o <= 1'b0;
      if (start_cond) begin
        active_q   <= 1'b1;
        in_ack_q   <= 1'b0;
        bcnt_q     <= '0;
        phase_q    <= PH_ADDR;
        sda_pull_o <= 1'b0;
      end else if (stop_cond) begin
        active_q   <= 1'b0;
        in_ack_q   <= 1'b0;
        sda_pull_o <= 1'b0;
      end else if (active_q) begin
        if (scl_rise_i && !in_ack_q && bcnt_q != 4'd8) begin
          shreg_q <= {shreg_q[6:0], sda_i};
          bcnt_q  <= bcnt_q + 1'b1;
        end else if (scl_fall_i) begin
          if (in_ack_q) begin
            in_ack_q   <= 1'b0;
            sda_pull_o <= 1'b0;
            bcnt_q     <= '0;
          end else if (bcnt_q == 4'd8) begin
            if (phase_q == PH_ADDR) begin
              if (shreg_q == DEV_ADDR) begin
                in_ack_q   <= 1'b1;
                sda_pull_o <= 1'b1;
                phase_q    <= PH_SUB;
              end else begin
                active_q <= 1'b0;
              end
            end else begin
              in_ack_q      <= 1'b1;
              sda_pull_o    <= 1'b1;
              byte_vld_o    <= 1'b1;
              byte_is_sub_o <= (phase_q == PH_SUB);
              byte_o        <= shreg_q;
              phase_q       <= PH_DATA;
            end
          end
        end
      end
    end
  end

  // R2: the acknowledge level never moves while SCL is high
  assert_ack_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && $past(scl_i) && !start_cond && !stop_cond) |-> $stable(sda_pull_o));
  // R2: a byte is delivered only on an SCL falling edge
  assert_byte_on_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> $past(scl_fall_i));
endmodule

// File: rtl/audio_reg_bank.sv
module audio_reg_bank
  import audio_ctl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       byte_vld_i,
  input  logic       byte_is_sub_i,
  input  logic [7:0] byte_i,
  output logic [2:0] input_sel_o,
  output logic [4:0] in_gain_o,
  output logic [5:0] vol_left_o,
  output logic [5:0] vol_right_o,
  output logic [1:0] mode_o,
  output logic [2:0] surround_o,
  output logic [2:0] sum_gain_o,
  output logic [4:0] bass_o,
  output logic [4:0] treble_o,
  output logic       upd_o,
  output logic [2:0] upd_addr_o
);
  logic [7:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q       <= '0;
      input_sel_o <= '0;
      in_gain_o   <= '0;
      vol_left_o  <= VOL_MUTE;
      vol_right_o <= VOL_MUTE;
      mode_o      <= '0;
      surround_o  <= '0;
      sum_gain_o  <= '0;
      bass_o      <= '0;
      treble_o    <= '0;
      upd_o       <= 1'b0;
      upd_addr_o  <= '0;
    end else begin
      upd_o <= 1'b0;
      if (byte_vld_i) begin
        if (byte_is_sub_i) begin
          ptr_q <= byte_i;
        end else begin
          if (ptr_q != 8'hFF) ptr_q <= ptr_q + 1'b1;  // saturate: never wrap into the map
          upd_addr_o <= ptr_q[2:0];
          unique case (ptr_q)
            8'd1: begin
              input_sel_o <= byte_i[2:0];
              in_gain_o   <= byte_i[7:3];
              upd_o       <= 1'b1;
            end
            8'd2: begin
              if (byte_i[6]) vol_left_o  <= vol_clamp(byte_i[5:0]);
              if (byte_i[7]) vol_right_o <= vol_clamp(byte_i[5:0]);
              upd_o <= |byte_i[7:6];
            end
            8'd3: begin
              mode_o     <= byte_i[1:0];
              surround_o <= byte_i[4:2];
              sum_gain_o <= byte_i[7:5];
              upd_o      <= 1'b1;
            end
            8'd4: begin
              bass_o <= tone_clamp(byte_i[4:0], BASS_MAX);
              upd_o  <= 1'b1;
            end
            8'd5: begin
              treble_o <= tone_clamp(byte_i[4:0], TREBLE_MAX);
              upd_o    <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  assert_upd_single_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> !upd_o);
  assert_upd_addr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> (upd_addr_o >= 3'd1 && upd_addr_o <= 3'd5));
  assert_vol_clamp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vol_left_o <= VOL_MUTE) && (vol_right_o <= VOL_MUTE));
  assert_tone_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bass_o[3:0] <= BASS_MAX) && (treble_o[3:0] <= TREBLE_MAX));
  assert_quiet_no_change_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_o |-> ($stable(vol_left_o) && $stable(bass_o) && $stable(input_sel_o)));
endmodule

// File: rtl/audio_ctl_i2c_slave.sv
module audio_ctl_i2c_slave
  import audio_ctl_pkg::*;
#(
  parameter int         FILT_LEN = 3,
  parameter logic [7:0] DEV_ADDR = 8'hEE
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  output logic [2:0] input_sel_o,
  output logic [4:0] in_gain_o,
  output logic [5:0] vol_left_o,
  output logic [5:0] vol_right_o,
  output logic [1:0] mode_o,
  output logic [2:0] surround_o,
  output logic [2:0] sum_gain_o,
  output logic [4:0] bass_o,
  output logic [4:0] treble_o,
  output logic       upd_o,
  output logic [2:0] upd_addr_o
);
  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic       byte_vld, byte_is_sub;
  logic [7:0] byte_val;
  logic [2:0] surround_raw;

  i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_scl_filt (
    .clk_i, .rst_ni, .raw_i(scl_i),
    .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_sda_filt (
    .clk_i, .rst_ni, .raw_i(sda_i),
    .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  i2c_wr_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
    .clk_i, .rst_ni,
    .scl_i(scl_lvl), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .sda_i(sda_lvl), .sda_rise_i(sda_rise), .sda_fall_i(sda_fall),
    .sda_pull_o, .byte_vld_o(byte_vld), .byte_is_sub_o(byte_is_sub), .byte_o(byte_val)
  );

  audio_reg_bank u_bank (
    .clk_i, .rst_ni,
    .byte_vld_i(byte_vld), .byte_is_sub_i(byte_is_sub), .byte_i(byte_val),
    .input_sel_o, .in_gain_o, .vol_left_o, .vol_right_o, .mode_o,
    .surround_o(surround_raw), .sum_gain_o, .bass_o, .treble_o,
    .upd_o, .upd_addr_o
  );

  // surround has no effect in forced mono
  assign surround_o = (mode_o == MODE_MONO) ? 3'd0 : surround_raw;

  assert_pull_low_scl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_o) |-> !scl_lvl);
endmodule

// File: tb/audio_ctl_i2c_slave_bench.sv
`timescale 1ns/1ps
module audio_ctl_i2c_slave_bench;
  localparam int Q = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull;
  logic [2:0] input_sel, surround, sum_gain, upd_addr;
  logic [4:0] in_gain, bass, treble;
  logic [5:0] vol_l, vol_r;
  logic [1:0] mode;
  logic upd;
  wire sda_line = sda_m & ~sda_pull;

  int checks = 0, errors = 0, upd_cnt = 0, last_addr = 0;

  always #4 clk = ~clk;

  audio_ctl_i2c_slave u_audio_ctl_i2c_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .input_sel_o(input_sel), .in_gain_o(in_gain),
    .vol_left_o(vol_l), .vol_right_o(vol_r), .mode_o(mode), .surround_o(surround),
    .sum_gain_o(sum_gain), .bass_o(bass), .treble_o(treble),
    .upd_o(upd), .upd_addr_o(upd_addr)
  );

  always @(negedge clk) if (upd) begin upd_cnt++; last_addr = int'(upd_addr); end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_q(input int n); repeat (n) @(posedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q(Q); scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b0; wait_q(Q); scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(Q); scl_m = 1'b1; wait_q(Q); sda_m = 1'b1; wait_q(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n, input int gbit);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i];
      if (i == gbit) begin
        wait_q(Q/2); scl_m = 1'b1; wait_q(1); scl_m = 1'b0; wait_q(Q - Q/2 - 1);
      end else wait_q(Q);
      scl_m = 1'b1; wait_q(2*Q); scl_m = 1'b0; wait_q(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int gbit, output bit ack);
    send_bits(b, 8, gbit);
    sda_m = 1'b1; wait_q(Q); scl_m = 1'b1; wait_q(Q);
    @(negedge clk); ack = (sda_line == 1'b0);
    wait_q(Q); scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic open_xfer(input logic [7:0] sub);
    bit a;
    bus_start(); send_byte(8'hEE, -1, a); send_byte(sub, -1, a);
  endtask

  task automatic put(input logic [7:0] b);
    bit a; send_byte(b, -1, a);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit a;
    int u0;
    wait_q(5); rst_n = 1'b1; wait_q(5);
    @(negedge clk);
    chk("R11 input_sel", input_sel, 0); chk("R11 vol_l", vol_l, 48);
    chk("R11 vol_r", vol_r, 48); chk("R11 sum_gain", sum_gain, 0);
    chk("R11 mode", mode, 0); chk("R11 bass", bass, 0); chk("R11 sda_pull", sda_pull, 0);

    // R1 R2 R4: full fill of the map
    u0 = upd_cnt;
    bus_start();
    send_byte(8'hEE, -1, a); chk("R1 address ack", a, 1);
    send_byte(8'h01, -1, a); chk("R2 sub ack", a, 1);
    send_byte(8'h39, -1, a); chk("R2 data ack", a, 1);
    put(8'hC5); put(8'h8D); put(8'h13); put(8'h07);
    bus_stop();
    @(negedge clk);
    chk("R2 released after stop", sda_pull, 0);
    chk("R5 input_sel", input_sel, 1); chk("R5 in_gain", in_gain, 7);
    chk("R4 vol_l", vol_l, 5); chk("R4 vol_r", vol_r, 5);
    chk("R8 mode", mode, 1); chk("R8 surround", surround, 3); chk("R8 sum_gain", sum_gain, 4);
    chk("R9 bass", bass, 5'h13); chk("R9 treble", treble, 7);
    chk("R12 strobe count", upd_cnt - u0, 5); chk("R12 last addr", last_addr, 5);

    // R6: channel steering
    open_xfer(8'h02); put(8'h4A); bus_stop(); @(negedge clk);
    chk("R6 left only", vol_l, 10); chk("R6 right kept", vol_r, 5);
    open_xfer(8'h02); put(8'h8C); bus_stop(); @(negedge clk);
    chk("R6 right only", vol_r, 12); chk("R6 left kept", vol_l, 10);
    u0 = upd_cnt;
    open_xfer(8'h02); put(8'h0F); bus_stop(); @(negedge clk);
    chk("R6 none vol_l", vol_l, 10); chk("R6 none vol_r", vol_r, 12);
    chk("R6 none strobe", upd_cnt - u0, 0);

    // R7: volume sweep, both channels
    for (int c = 0; c < 64; c++) begin
      int e;
      open_xfer(8'h02); put({2'b11, 6'(c)}); bus_stop(); @(negedge clk);
      e = (c > 48) ? 48 : c;
      chk("R7 volume both", int'({vol_l, vol_r}), int'({6'(e), 6'(e)}));
    end

    // R9: tone sweep through auto-increment
    for (int k = 0; k < 32; k++) begin
      int mag, eb, et;
      mag = k & 15;
      eb = (k & 16) | ((mag > 10) ? 10 : mag);
      et = (k & 16) | ((mag > 9) ? 9 : mag);
      open_xfer(8'h04); put(8'(k)); put(8'(k | 8'hE0)); bus_stop(); @(negedge clk);
      chk("R9 bass", bass, eb); chk("R9 treble", treble, et);
    end

    // R8: mono forces surround off
    open_xfer(8'h03); put(8'hB6); bus_stop(); @(negedge clk);
    chk("R8 mono mode", mode, 2); chk("R8 mono surround", surround, 0); chk("R8 sum", sum_gain, 5);
    open_xfer(8'h03); put(8'hB5); bus_stop(); @(negedge clk);
    chk("R8 matrix surround", surround, 5);

    // R10: out-of-range pointers
    u0 = upd_cnt;
    bus_start(); put(8'hEE); put(8'h00);
    send_byte(8'h55, -1, a); chk("R10 ptr0 ack", a, 1);
    bus_stop();
    bus_start(); put(8'hEE); put(8'h06);
    send_byte(8'h55, -1, a); chk("R10 ptr6 ack", a, 1);
    bus_stop(); @(negedge clk);
    chk("R10 no strobe", upd_cnt - u0, 0); chk("R10 input_sel kept", input_sel, 1);
    open_xfer(8'h05); put(8'h02);
    send_byte(8'h08, -1, a); chk("R10 past end ack", a, 1);
    bus_stop(); @(negedge clk);
    chk("R10 treble first only", treble, 2); chk("R10 one strobe", upd_cnt - u0, 1);

    // R1: wrong addresses
    bus_start(); send_byte(8'hEF, -1, a); chk("R1 read nack", a, 0);
    send_byte(8'h01, -1, a); chk("R1 following byte nack", a, 0);
    put(8'h03); bus_stop();
    bus_start(); send_byte(8'hEC, -1, a); chk("R1 other nack", a, 0); bus_stop();
    @(negedge clk); chk("R1 nothing stored", input_sel, 1);

    // R3: START mid-byte restarts address decoding
    u0 = upd_cnt;
    open_xfer(8'h01); send_bits(8'hFF, 4, -1);
    bus_start(); send_byte(8'hEE, -1, a); chk("R3 address after restart", a, 1);
    put(8'h01); put(8'h12); bus_stop(); @(negedge clk);
    chk("R3 input_sel", input_sel, 2); chk("R3 in_gain", in_gain, 2);
    chk("R3 one strobe", upd_cnt - u0, 1);

    // R13: short SCL spike in the low phase
    open_xfer(8'h01);
    send_byte(8'h1B, 5, a); chk("R13 ack", a, 1);
    bus_stop(); @(negedge clk);
    chk("R13 input_sel", input_sel, 3); chk("R13 in_gain", in_gain, 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule